// File: doc/BRIEF.md
# Dual H-Bridge Control and Protection Core

This block is the digital control core of a driver with two full bridges. Two logic inputs per bridge select coast, forward, reverse or brake. Each of the four bridge outputs is driven through a source-enable and a sink-enable, so an output can be high, low or off. The enables are registered and follow the command inputs one clock later.

Around the decoder sit four guards. A standby timer puts the whole block to sleep once every command input has stayed low for a set number of cycles. Each bridge has a filtered fault detector that watches a source-overcurrent flag and a sink-overvoltage flag. A confirmed fault switches off only that bridge for a fixed retry window. A thermal latch, set by a trip flag and released by a separate recovery flag, turns off everything. An undervoltage input does the same for as long as it is held. All intervals are parameters counted in clock cycles, so the block can follow any clock.

Top module: `hbridge_ctrl`

## Requirements
- R1: Bridge b is commanded by `in_cmd[2b]` (A) and `in_cmd[2b+1]` (B). Its outputs are 2b (first) and 2b+1 (second). With nothing blocking, the enables update one clock after the command is sampled, as follows. A=0,B=0 turns all four switches off. A=1,B=0 drives the first output high and the second low. A=0,B=1 drives the first output low and the second high. A=1,B=1 drives both outputs low.
- R2: No output ever has `src_en` and `snk_en` set together.
- R3: Once all four command inputs are low, the count starts. When they have been low at SLEEP_CYC consecutive clock edges, `sleep` rises at the next edge if they are still low. While `sleep` is high, all enables are zero.
- R4: The first edge that samples any command input high clears `sleep`. The enables stay off at that edge and drive the command from the following edge on.
- R5: On bridge b, either fault flag (`oc_src[b]` or `oc_snk[b]`) may stay high continuously. At the (FILT_CYC+1)-th consecutive edge that samples it high, `bridge_fault[b]` rises. At that same edge the bridge's four enables go to zero.
- R6: A fault flag that drops after FILT_CYC edges or fewer leaves `bridge_fault` low. It also restarts the filter from zero.
- R7: `bridge_fault[b]` stays high for exactly RETRY_CYC cycles, and the bridge's commands are ignored during that time. The bridge drives its command again from the edge after `bridge_fault[b]` falls.
- R8: A fault on one bridge leaves the other bridge's enables unchanged.
- R9: The edge that samples `tsd_trip` high turns all enables off. They stay off until an edge samples `tsd_clear` high with `tsd_trip` low, and at that edge they follow the command again.
- R10: An edge that samples `uvlo` high sets all enables to zero. The first edge that samples it low again restores them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_cmd | input | 4 | Command inputs, two per bridge |
| oc_src | input | 2 | Per-bridge source overcurrent flag |
| oc_snk | input | 2 | Per-bridge sink overvoltage flag |
| tsd_trip | input | 1 | Thermal trip flag |
| tsd_clear | input | 1 | Thermal recovery flag |
| uvlo | input | 1 | Undervoltage lockout, active high |
| src_en | output | 4 | Source switch enable per output |
| snk_en | output | 4 | Sink switch enable per output |
| sleep | output | 1 | Standby flag |
| bridge_fault | output | 2 | Per-bridge fault and retry flag |

## Verification
A standby counter off by one moves the rise of `sleep` by one edge. The bench samples both sides of that edge. A filter counter that fails to restart turns the second short fault pulse into a fault. A retry counter off by one shifts the fall of `bridge_fault` and the return of the bridge by one edge, and the bench samples both of those boundaries. A thermal latch that does not hold would drive the outputs within one clock of the trip flag dropping, well before the recovery flag.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
  // Bridge command as {B, A}
  typedef enum logic [1:0] {
    BR_COAST = 2'b00,
    BR_FWD   = 2'b01,
    BR_REV   = 2'b10,
    BR_BRAKE = 2'b11
  } br_cmd_e;

  typedef struct packed {
    logic [1:0] src;
    logic [1:0] snk;
  } br_drive_t;

  localparam int unsigned NUM_BR = 2;
endpackage

// File: rtl/hb_decode.sv
`timescale 1ns/1ps
module hb_decode
  import hb_pkg::*;
(
  input  logic      cmd_a,
  input  logic      cmd_b,
  input  logic      enable,
  output br_drive_t drive
);
  br_cmd_e cmd;

  always_comb begin
    cmd   = br_cmd_e'({cmd_b, cmd_a});
    drive = '0;
    if (enable) begin
      unique case (cmd)
        BR_FWD:   begin drive.src = 2'b01; drive.snk = 2'b10; end
        BR_REV:   begin drive.src = 2'b10; drive.snk = 2'b01; end
        BR_BRAKE: begin drive.src = 2'b00; drive.snk = 2'b11; end
        default:  drive = '0;
      endcase
    end
  end
endmodule

// File: rtl/hb_standby.sv
`timescale 1ns/1ps
module hb_standby #(
  parameter int unsigned SLEEP_CYC = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic all_low,
  output logic sleep
);
  localparam int unsigned CW = $clog2(SLEEP_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sleep_q, sleep_d;
  logic          cnt_en;

  always_comb begin
    cnt_d   = cnt_q;
    sleep_d = sleep_q;
    if (!all_low) begin
      cnt_d   = '0;
      sleep_d = 1'b0;
    end else if (cnt_q == CW'(SLEEP_CYC)) begin
      sleep_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign cnt_en = (cnt_d != cnt_q) || (sleep_d != sleep_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sleep_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      sleep_q <= sleep_d;
    end
  end

  assign sleep = sleep_q;
endmodule

// File: rtl/hb_fault_guard.sv
`timescale 1ns/1ps
module hb_fault_guard #(
  parameter int unsigned FILT_CYC  = 250,
  parameter int unsigned RETRY_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ind,
  output logic fault,
  output logic block
);
  localparam int unsigned FW = $clog2(FILT_CYC + 1);
  localparam int unsigned RW = $clog2(RETRY_CYC + 1);

  logic [FW-1:0] filt_q, filt_d;
  logic [RW-1:0] rc_q, rc_d;
  logic          flt_q, flt_d;
  logic          trip;

  always_comb begin
    filt_d = filt_q;
    rc_d   = rc_q;
    flt_d  = flt_q;
    trip   = 1'b0;
    if (flt_q) begin
      filt_d = '0;
      if (rc_q == RW'(RETRY_CYC - 1)) begin
        flt_d = 1'b0;
        rc_d  = '0;
      end else begin
        rc_d = rc_q + 1'b1;
      end
    end else if (!ind) begin
      filt_d = '0;
    end else if (filt_q == FW'(FILT_CYC)) begin
      trip   = 1'b1;
      flt_d  = 1'b1;
      filt_d = '0;
    end else begin
      filt_d = filt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= '0;
      rc_q   <= '0;
      flt_q  <= 1'b0;
    end else begin
      filt_q <= filt_d;
      rc_q   <= rc_d;
      flt_q  <= flt_d;
    end
  end

  assign fault = flt_q;
  assign block = flt_q | trip;
endmodule

// File: rtl/hbridge_ctrl.sv
`timescale 1ns/1ps
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned SLEEP_CYC = 125000,
  parameter int unsigned FILT_CYC  = 250,
  parameter int unsigned RETRY_CYC = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] in_cmd,
  input  logic [1:0] oc_src,
  input  logic [1:0] oc_snk,
  input  logic       tsd_trip,
  input  logic       tsd_clear,
  input  logic       uvlo,
  output logic [3:0] src_en,
  output logic [3:0] snk_en,
  output logic       sleep,
  output logic [1:0] bridge_fault
);
  localparam int unsigned NOUT = 2 * NUM_BR;

  logic            sleep_q;
  logic            tsd_q, tsd_d;
  logic            global_off;
  logic [NUM_BR-1:0] blk;
  logic [NOUT-1:0] src_d, snk_d, src_q, snk_q;
  br_drive_t       drv [NUM_BR];

  hb_standby #(.SLEEP_CYC(SLEEP_CYC)) u_standby (
    .clk     (clk),
    .rst_n   (rst_n),
    .all_low (in_cmd == '0),
    .sleep   (sleep_q)
  );

  // thermal latch: trip has priority over recovery
  always_comb begin
    tsd_d = tsd_q;
    if (tsd_trip)       tsd_d = 1'b1;
    else if (tsd_clear) tsd_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tsd_q <= 1'b0;
    else        tsd_q <= tsd_d;
  end

  assign global_off = sleep_q | uvlo | tsd_d;

  for (genvar b = 0; b < NUM_BR; b++) begin : g_br
    hb_fault_guard #(
      .FILT_CYC  (FILT_CYC),
      .RETRY_CYC (RETRY_CYC)
    ) u_guard (
      .clk   (clk),
      .rst_n (rst_n),
      .ind   (oc_src[b] | oc_snk[b]),
      .fault (bridge_fault[b]),
      .block (blk[b])
    );

    hb_decode u_dec (
      .cmd_a  (in_cmd[2*b]),
      .cmd_b  (in_cmd[2*b+1]),
      .enable (!global_off && !blk[b]),
      .drive  (drv[b])
    );

    assign src_d[2*b +: 2] = drv[b].src;
    assign snk_d[2*b +: 2] = drv[b].snk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      snk_q <= '0;
    end else begin
      src_q <= src_d;
      snk_q <= snk_d;
    end
  end

  assign src_en = src_q;
  assign snk_en = snk_q;
  assign sleep  = sleep_q;
endmodule

// File: rtl/hbridge_ctrl_chk.sv
`timescale 1ns/1ps
module hbridge_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] in_cmd,
  input logic       uvlo,
  input logic [3:0] src_en,
  input logic [3:0] snk_en,
  input logic       sleep,
  input logic [1:0] bridge_fault
);
  a_r2_no_cross_conduction: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en & snk_en) == 4'b0000);

  a_r3_sleep_outputs_off: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (src_en == 4'b0000 && snk_en == 4'b0000));

  a_r3_sleep_needs_low_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> ($past(in_cmd) == 4'b0000));

  a_r4_wake_still_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> (src_en == 4'b0000 && snk_en == 4'b0000));

  a_r5_fault_br0_off: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_fault[0] |-> (src_en[1:0] == 2'b00 && snk_en[1:0] == 2'b00));

  a_r5_fault_br1_off: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_fault[1] |-> (src_en[3:2] == 2'b00 && snk_en[3:2] == 2'b00));

  a_r7_retry_edge_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bridge_fault[0]) |-> (src_en[1:0] == 2'b00 && snk_en[1:0] == 2'b00));

  a_r10_uvlo_off: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (src_en == 4'b0000 && snk_en == 4'b0000));
endmodule

bind hbridge_ctrl hbridge_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_cmd       (in_cmd),
  .uvlo         (uvlo),
  .src_en       (src_en),
  .snk_en       (snk_en),
  .sleep        (sleep),
  .bridge_fault (bridge_fault)
);

// File: tb/test_hbridge_ctrl.sv
`timescale 1ns/1ps
module test_hbridge_ctrl;
  localparam int S = 40;
  localparam int F = 5;
  localparam int R = 30;

  logic       clk;
  logic       rst_n;
  logic [3:0] in_cmd;
  logic [1:0] oc_src, oc_snk;
  logic       tsd_trip, tsd_clear, uvlo;
  logic [3:0] src_en, snk_en;
  logic       sleep;
  logic [1:0] bridge_fault;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  hbridge_ctrl #(.SLEEP_CYC(S), .FILT_CYC(F), .RETRY_CYC(R)) i_hbridge_ctrl (
    .clk(clk), .rst_n(rst_n), .in_cmd(in_cmd), .oc_src(oc_src), .oc_snk(oc_snk),
    .tsd_trip(tsd_trip), .tsd_clear(tsd_clear), .uvlo(uvlo),
    .src_en(src_en), .snk_en(snk_en), .sleep(sleep), .bridge_fault(bridge_fault)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // expected {src, snk} from the command table
  function automatic logic [7:0] model(input logic [3:0] c);
    logic [3:0] s, k;
    s = '0; k = '0;
    for (int b = 0; b < 2; b++) begin
      case ({c[2*b+1], c[2*b]})
        2'b01: begin s[2*b] = 1'b1; k[2*b+1] = 1'b1; end
        2'b10: begin k[2*b] = 1'b1; s[2*b+1] = 1'b1; end
        2'b11: begin k[2*b] = 1'b1; k[2*b+1] = 1'b1; end
        default: ;
      endcase
    end
    return {s, k};
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; in_cmd = '0; oc_src = '0; oc_snk = '0;
    tsd_trip = 0; tsd_clear = 0; uvlo = 0;
    tick(3);
    chk("reset R1 outputs", {8'h0, src_en, snk_en}, 16'h0);
    chk("reset R3 sleep", {15'h0, sleep}, 16'h0);
    chk("reset R5 fault", {14'h0, bridge_fault}, 16'h0);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_decode;
    for (int c = 1; c < 16; c++) begin
      in_cmd = 4'(c);
      tick(1);
      chk($sformatf("R1 decode %0d", c), {8'h0, src_en, snk_en}, {8'h0, model(4'(c))});
      chk("R2 no cross", {12'h0, src_en & snk_en}, 16'h0);
    end
  endtask

  task automatic t_sleep_wake;
    in_cmd = 4'b0001; tick(2);
    in_cmd = 4'b0000; tick(S);
    chk("R3 not yet asleep", {15'h0, sleep}, 16'h0);
    tick(1);
    chk("R3 asleep", {15'h0, sleep}, 16'h1);
    chk("R3 outputs off", {8'h0, src_en, snk_en}, 16'h0);
    in_cmd = 4'b0001; tick(1);
    chk("R4 sleep cleared", {15'h0, sleep}, 16'h0);
    chk("R4 still off at wake", {8'h0, src_en, snk_en}, 16'h0);
    tick(1);
    chk("R4 driving", {8'h0, src_en, snk_en}, {8'h0, model(4'b0001)});
  endtask

  task automatic t_fault;
    in_cmd = 4'b0101; tick(1);
    oc_src[0] = 1'b1; tick(F);
    chk("R5 before filter", {14'h0, bridge_fault}, 16'h0);
    chk("R5 still driving", {8'h0, src_en, snk_en}, {8'h0, model(4'b0101)});
    tick(1);
    chk("R5 fault set", {14'h0, bridge_fault}, 16'h1);
    chk("R5 bridge0 off", {8'h0, src_en, snk_en}, {8'h0, model(4'b0100)});
    chk("R8 bridge1 unaffected", {12'h0, src_en[3:2], snk_en[3:2]}, {12'h0, 4'b0110});
    oc_src[0] = 1'b0;
    in_cmd = 4'b0111; tick(R - 1);
    chk("R7 still blocked", {14'h0, bridge_fault}, 16'h1);
    chk("R7 inputs ignored", {8'h0, src_en, snk_en}, {8'h0, model(4'b0100)});
    tick(1);
    chk("R7 retry window over", {14'h0, bridge_fault}, 16'h0);
    chk("R7 off at release edge", {12'h0, src_en[1:0], snk_en[1:0]}, 16'h0);
    tick(1);
    chk("R7 retried", {8'h0, src_en, snk_en}, {8'h0, model(4'b0111)});
  endtask

  task automatic t_glitch;
    in_cmd = 4'b1010; tick(1);
    oc_snk[1] = 1'b1; tick(F);
    oc_snk[1] = 1'b0; tick(1);
    oc_snk[1] = 1'b1; tick(F);
    oc_snk[1] = 1'b0; tick(1);
    chk("R6 no fault after short pulses", {14'h0, bridge_fault}, 16'h0);
    chk("R6 still driving", {8'h0, src_en, snk_en}, {8'h0, model(4'b1010)});
  endtask

  task automatic t_thermal;
    in_cmd = 4'b1001; tick(1);
    tsd_trip = 1'b1; tick(1);
    chk("R9 trip off", {8'h0, src_en, snk_en}, 16'h0);
    tsd_trip = 1'b0; tick(3);
    chk("R9 held off", {8'h0, src_en, snk_en}, 16'h0);
    tsd_clear = 1'b1; tick(1);
    chk("R9 recovered", {8'h0, src_en, snk_en}, {8'h0, model(4'b1001)});
    tsd_clear = 1'b0;
  endtask

  task automatic t_uvlo;
    in_cmd = 4'b1111; tick(1);
    uvlo = 1'b1; tick(1);
    chk("R10 lockout off", {8'h0, src_en, snk_en}, 16'h0);
    uvlo = 1'b0; tick(1);
    chk("R10 restored", {8'h0, src_en, snk_en}, {8'h0, model(4'b1111)});
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_decode();
    t_sleep_wake();
    t_fault();
    t_glitch();
    t_thermal();
    t_uvlo();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule